// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Fill Freeze and Scratch Mode

This block sits between a CPU-side load/store port and an external memory port. It holds a direct-mapped data cache of 64 lines, each 16 bytes and aligned on a 16-byte boundary. Two mode inputs shape its policy. `alloc_off` stops new lines from being allocated, but valid lines keep serving hits. `wr_hold` keeps write hits inside the cache instead of passing them on to memory. A base/mask pair selects which addresses may be cached, and a one-cycle `inv_all` pulse drops every line without writing anything back.

Used together, these controls let boot software fill a region into the cache and then set `alloc_off` and `wr_hold`. From then on the cached region behaves as private scratch RAM, and none of its writes ever reach external memory. When the region is no longer needed, an invalidate discards its contents.

Top module: `scratch_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `mem_req` and `req_ready` are low, and the first cacheable read misses.
- R2: A cacheable read miss with `alloc_off`=0 fills the line with four 32-bit memory reads, in the order word 0, 1, 2, 3 of the 16-byte-aligned line. It then raises `req_ready` with the requested word. A later read in the same line hits and makes no memory access.
- R3: With `alloc_off`=1, a read miss makes exactly one memory read at the request address and allocates nothing, so repeating the read goes to memory again.
- R4: With `alloc_off`=1, a read that hits a valid line is served from the cache with no memory access.
- R5: With `wr_hold`=1, a write that hits updates only the cached word. No memory write occurs, and a later read returns the new data.
- R6: With `wr_hold`=0, every write makes one memory write. A write hit also updates the cached word. A write miss allocates no line.
- R7: Cached data left stale by `wr_hold` writes is never written out: not when `wr_hold` is cleared, and not when the line is replaced by a fill. Memory writes occur only while the CPU presents a write.
- R8: A one-cycle `inv_all` pulse clears every valid bit, and the next read of any previously cached line misses. No memory write is issued.
- R9: An `inv_all` that arrives during a fill takes effect after the fill completes. The fill's read still returns the fetched word, and the line just filled is invalid afterwards.
- R10: An address is cacheable only when ((addr ^ `range_base`) & `range_mask`) == 0. Other accesses go straight to memory, never hit, never allocate, and their writes reach memory even with `wr_hold`=1.
- R11: The line index is address bits [9:4] and the tag is bits [31:10]. Two cacheable addresses with equal index and different tag replace each other.
- R12: `req_ready` is high for exactly one cycle per accepted request. `mem_req` and `mem_addr` stay steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_off | input | 1 | 1: no line allocation on read misses |
| wr_hold | input | 1 | 1: write hits stay in the cache only |
| inv_all | input | 1 | One-cycle pulse: invalidate every line, no write-back |
| range_base | input | 32 | Base of the cacheable range |
| range_mask | input | 32 | Address bits compared against the base |
| req_valid | input | 1 | CPU request present, held until `req_ready` |
| req_we | input | 1 | 1: write, 0: read |
| req_addr | input | 32 | Word address (byte address, low two bits zero) |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request completes in this cycle |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the access; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Reads are driven first with all modes clear, which separates a cold miss (four ordered fill reads) from a hit (no memory access). Write-through hits and write-through misses are then told apart by whether a following read costs a fill. With allocation frozen, the bench alternates misses and hits, which shows that a miss leaves nothing behind while a hit still answers. Held writes are followed by a conflicting fill, a range change and invalidates (one of them mid-fill). Read-back values and memory write counts then show whether any stale word escaped or any line survived.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
package scc_pkg;
  // Sequencer states of the cache controller
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_RD1  = 3'd2,
    ST_WR1  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/scc_range_chk.sv
`timescale 1ns/1ps
// Cacheability decision from one base/mask range (R10)
module scc_range_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              in_range
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff     = (addr ^ base) & mask;
    in_range = (diff == '0);
  end
endmodule

// File: rtl/scc_tag_store.sv
`timescale 1ns/1ps
// Valid bits and tags, one entry per line; global clear drops all valids.
module scc_tag_store #(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_match,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_all,
  output logic [LINES-1:0] valid_vec
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_set;
    assign hit_set = set_en && (set_idx == IDX_W'(g));

    always_comb begin
      if (clr_all)      valid_d[g] = 1'b0;
      else if (hit_set) valid_d[g] = 1'b1;
      else              valid_d[g] = valid_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[g] <= 1'b0;
      else        valid_q[g] <= valid_d[g];
    end

    always_ff @(posedge clk) begin
      if (hit_set) tag_q[g] <= set_tag;
    end
  end

  always_comb begin
    rd_match  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    valid_vec = valid_q;
  end
endmodule

// File: rtl/scc_data_store.sv
`timescale 1ns/1ps
// Word-organised data array: asynchronous read, one synchronous write port.
module scc_data_store #(
  parameter int DATA_W = 32,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_addr] <= wr_data;
  end

  assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/scc_seq.sv
`timescale 1ns/1ps
// Request sequencer: hit service, line fill, single read, write-through.
module scc_seq
  import scc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int WSEL_W = 2,
  parameter int OFS_W  = 4,
  parameter int TAG_W  = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_off,
  input  logic                    wr_hold,
  input  logic                    inv_req,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic [DATA_W-1:0]       req_rdata,
  input  logic                    lookup_hit,
  input  logic                    in_range,
  input  logic [DATA_W-1:0]       line_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    tag_set,
  output logic [IDX_W-1:0]        tag_idx,
  output logic [TAG_W-1:0]        tag_val,
  output logic                    clr_all,
  output logic                    dat_we,
  output logic [IDX_W+WSEL_W-1:0] dat_addr,
  output logic [DATA_W-1:0]       dat_wdata,
  output seq_state_e              state_o,
  output logic                    inv_pend_o
);
  localparam int BYTE_W = OFS_W - WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = {WSEL_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              inv_q, inv_d;
  logic              cap_en, cnt_en, hold_en;

  logic [WSEL_W-1:0] cur_word;
  logic [IDX_W-1:0]  cur_idx;

  assign cur_word = addr_q[OFS_W-1:BYTE_W];
  assign cur_idx  = addr_q[OFS_W+IDX_W-1:OFS_W];

  always_comb begin
    state_d   = state_q;
    inv_d     = inv_q | inv_req;
    cap_en    = 1'b0;
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    hold_en   = 1'b0;
    hold_d    = hold_q;
    req_ready = 1'b0;
    req_rdata = '0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    tag_set   = 1'b0;
    clr_all   = 1'b0;
    dat_we    = 1'b0;
    dat_addr  = req_addr[OFS_W+IDX_W-1:BYTE_W];
    dat_wdata = req_wdata;

    case (state_q)
      ST_IDLE: begin
        if (inv_q) begin
          // pending invalidate has priority over a new request
          clr_all = 1'b1;
          inv_d   = inv_req;
        end else if (req_valid) begin
          if (!req_we) begin
            if (lookup_hit) begin
              req_ready = 1'b1;
              req_rdata = line_rdata;
            end else begin
              cap_en = 1'b1;
              if (in_range && !alloc_off) begin
                state_d = ST_FILL;
                cnt_en  = 1'b1;
                cnt_d   = '0;
              end else begin
                state_d = ST_RD1;
              end
            end
          end else begin
            dat_we = lookup_hit;
            if (lookup_hit && wr_hold) begin
              req_ready = 1'b1;
            end else begin
              cap_en  = 1'b1;
              state_d = ST_WR1;
            end
          end
        end
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_addr  = {addr_q[ADDR_W-1:OFS_W], cnt_q, {BYTE_W{1'b0}}};
        dat_addr  = {cur_idx, cnt_q};
        dat_wdata = mem_rdata;
        if (mem_ack) begin
          dat_we = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = cnt_q + WSEL_W'(1);
          if (cnt_q == cur_word) begin
            hold_en = 1'b1;
            hold_d  = mem_rdata;
          end
          if (cnt_q == LAST_WORD) begin
            tag_set = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_RD1: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          hold_en = 1'b1;
          hold_d  = mem_rdata;
          state_d = ST_DONE;
        end
      end
      ST_WR1: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: begin
        req_ready = 1'b1;
        req_rdata = hold_q;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tag_idx    = cur_idx;
  assign tag_val    = addr_q[ADDR_W-1:OFS_W+IDX_W];
  assign state_o    = state_q;
  assign inv_pend_o = inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      inv_q   <= inv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
    if (cnt_en)  cnt_q  <= cnt_d;
    if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/scratch_cache_ctrl.sv
`timescale 1ns/1ps
// Top: direct-mapped data cache controller with allocation freeze,
// write-hold and discard-all invalidate.
module scratch_cache_ctrl
  import scc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 64,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_off,
  input  logic              wr_hold,
  input  logic              inv_all,
  input  logic [ADDR_W-1:0] range_base,
  input  logic [ADDR_W-1:0] range_mask,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFS_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int DAW    = IDX_W + WSEL_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic              in_range, tag_match, lookup_hit;
  logic              tag_set, clr_all, dat_we;
  logic [IDX_W-1:0]  tag_idx;
  logic [TAG_W-1:0]  tag_val;
  logic [DAW-1:0]    dat_addr;
  logic [DATA_W-1:0] dat_wdata, line_rdata;
  logic [LINES-1:0]  valid_vec;
  seq_state_e        state_q;
  logic              inv_pend;

  scc_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .addr     (req_addr),
    .base     (range_base),
    .mask     (range_mask),
    .in_range (in_range)
  );

  scc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_q),
    .rd_idx    (req_addr[OFS_W+IDX_W-1:OFS_W]),
    .rd_tag    (req_addr[ADDR_W-1:OFS_W+IDX_W]),
    .rd_match  (tag_match),
    .set_en    (tag_set),
    .set_idx   (tag_idx),
    .set_tag   (tag_val),
    .clr_all   (clr_all),
    .valid_vec (valid_vec)
  );

  assign lookup_hit = tag_match && in_range;

  scc_data_store #(.DATA_W(DATA_W), .AW(DAW)) u_data (
    .clk     (clk),
    .rd_addr (req_addr[OFS_W+IDX_W-1:BYTE_W]),
    .rd_data (line_rdata),
    .wr_en   (dat_we),
    .wr_addr (dat_addr),
    .wr_data (dat_wdata)
  );

  scc_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .WSEL_W(WSEL_W), .OFS_W(OFS_W), .TAG_W(TAG_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_q),
    .alloc_off  (alloc_off),
    .wr_hold    (wr_hold),
    .inv_req    (inv_all),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .req_rdata  (req_rdata),
    .lookup_hit (lookup_hit),
    .in_range   (in_range),
    .line_rdata (line_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .tag_set    (tag_set),
    .tag_idx    (tag_idx),
    .tag_val    (tag_val),
    .clr_all    (clr_all),
    .dat_we     (dat_we),
    .dat_addr   (dat_addr),
    .dat_wdata  (dat_wdata),
    .state_o    (state_q),
    .inv_pend_o (inv_pend)
  );
endmodule

// File: rtl/scc_checker.sv
`timescale 1ns/1ps
module scc_checker
  import scc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_off,
  input logic              req_valid,
  input logic              req_we,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input seq_state_e        state,
  input logic              inv_pend,
  input logic [LINES-1:0]  valid_vec
);
  logic fill_active;
  assign fill_active = (state == ST_FILL);

  // R7: memory writes only while the CPU itself presents a write
  assert_mem_write_from_cpu_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (req_valid && req_we));

  // R12: memory request and address held until acknowledged
  assert_mem_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8: an applied invalidate leaves no valid line
  assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && inv_pend) |=> (valid_vec == '0));

  // R3: a fill only starts when allocation was allowed
  assert_fill_needs_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_active) |-> $past(!alloc_off));

  // R4: an immediate answer never goes with a memory access
  assert_hit_no_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && req_ready) |-> !mem_req);
endmodule

bind scratch_cache_ctrl scc_checker #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .alloc_off (alloc_off),
  .req_valid (req_valid),
  .req_we    (req_we),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .state     (state_q),
  .inv_pend  (inv_pend),
  .valid_vec (valid_vec)
);

// File: tb/scratch_cache_ctrl_tb.sv
`timescale 1ns/1ps
module scratch_cache_ctrl_tb;
  logic        clk;
  logic        rst_n;
  logic        alloc_off, wr_hold, inv_all;
  logic [31:0] range_base, range_mask;
  logic        req_valid, req_we;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_cnt   = 0;
  int wr_cnt   = 0;
  logic [31:0] rd_log [$];
  logic [31:0] exp_q  [$];
  string       name_q [$];
  logic [31:0] mem [2048];

  scratch_cache_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5A00_0000 + {21'd0, a[12:2]} * 32'h0000_0101;
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // external memory model: one access per request, registered acknowledge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = pat(32'(i) << 2);
  end
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]] <= mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        rd_cnt++;
        rd_log.push_back(mem_addr);
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // scoreboard monitor: compares read answers against queued expectations
  always begin
    @(negedge clk);
    #5;
    if (req_valid && req_ready && !req_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected read answer", req_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string nm;
        e  = exp_q.pop_front();
        nm = name_q.pop_front();
        chk(req_rdata == e, nm, req_rdata, e);
      end
    end
  end

  task automatic cpu_access(input bit we, input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    forever begin
      #5;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    #4 chk(!req_ready, "R12 ready single pulse", {31'd0, req_ready}, 32'd0);
  endtask

  task automatic cpu_rd(input logic [31:0] a, input logic [31:0] e, input int exp_rd, input string r);
    int n0;
    n0 = rd_cnt;
    exp_q.push_back(e);
    name_q.push_back({r, " read data"});
    cpu_access(1'b0, a, 32'h0);
    chk(rd_cnt - n0 == exp_rd, {r, " memory reads"}, 32'(rd_cnt - n0), 32'(exp_rd));
  endtask

  task automatic cpu_wr(input logic [31:0] a, input logic [31:0] d, input int exp_wr, input string r);
    int w0;
    w0 = wr_cnt;
    cpu_access(1'b1, a, d);
    chk(wr_cnt - w0 == exp_wr, {r, " memory writes"}, 32'(wr_cnt - w0), 32'(exp_wr));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int w0;
    rst_n = 1'b0; alloc_off = 1'b0; wr_hold = 1'b0; inv_all = 1'b0;
    range_base = 32'h0000_1000; range_mask = 32'hFFFF_F000;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    // R1 reset state
    chk(!mem_req, "R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(!req_ready, "R1 req_ready after reset", {31'd0, req_ready}, 32'd0);

    // R1/R2 cold miss fills four words in order
    rd_log.delete();
    cpu_rd(32'h1024, pat(32'h1024), 4, "R1 R2 cold fill");
    for (int i = 0; i < 4; i++)
      chk(rd_log[i] == 32'h1020 + 32'(i * 4), "R2 fill order", rd_log[i], 32'h1020 + 32'(i * 4));
    cpu_rd(32'h102C, pat(32'h102C), 0, "R2 hit same line");

    // R6 write-through hit and miss
    cpu_wr(32'h1028, 32'hD1D1_0001, 1, "R6 hit write-through");
    chk(mem[32'h1028 >> 2] == 32'hD1D1_0001, "R6 memory updated", mem[32'h1028 >> 2], 32'hD1D1_0001);
    cpu_rd(32'h1028, 32'hD1D1_0001, 0, "R6 hit updated cache");
    cpu_wr(32'h1100, 32'hD2D2_0002, 1, "R6 miss write-through");
    cpu_rd(32'h1100, 32'hD2D2_0002, 4, "R6 miss did not allocate");

    // R3/R4 allocation frozen
    alloc_off = 1'b1;
    cpu_rd(32'h1200, pat(32'h1200), 1, "R3 miss single read");
    cpu_rd(32'h1200, pat(32'h1200), 1, "R3 no allocation");
    cpu_rd(32'h1024, pat(32'h1024), 0, "R4 hit while frozen");

    // R5 held write stays in cache
    wr_hold = 1'b1;
    cpu_wr(32'h1024, 32'hD3D3_0003, 0, "R5 held write");
    cpu_rd(32'h1024, 32'hD3D3_0003, 0, "R5 read back held data");
    chk(mem[32'h1024 >> 2] == pat(32'h1024), "R5 memory untouched", mem[32'h1024 >> 2], pat(32'h1024));

    // R7/R11 stale data lost on release and conflict replacement
    @(negedge clk);
    w0 = wr_cnt;
    wr_hold = 1'b0; alloc_off = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R7 no write when hold cleared", 32'(wr_cnt - w0), 32'd0);
    cpu_rd(32'h1424, pat(32'h1424), 4, "R11 R7 conflicting fill");
    cpu_rd(32'h1024, pat(32'h1024), 4, "R11 R7 line replaced stale lost");
    chk(mem[32'h1024 >> 2] == pat(32'h1024), "R7 stale never written", mem[32'h1024 >> 2], pat(32'h1024));

    // R10 out-of-range bypass
    cpu_rd(32'h2024, pat(32'h2024), 1, "R10 uncached read");
    cpu_rd(32'h2024, pat(32'h2024), 1, "R10 uncached not allocated");
    wr_hold = 1'b1;
    cpu_wr(32'h2030, 32'hD4D4_0004, 1, "R10 uncached write reaches memory");
    chk(mem[32'h2030 >> 2 & 32'h7FF] == 32'hD4D4_0004, "R10 memory value",
        mem[32'h2030 >> 2 & 32'h7FF], 32'hD4D4_0004);
    @(negedge clk);
    range_base = 32'h0000_3000;
    cpu_rd(32'h1024, pat(32'h1024), 1, "R10 valid line outside range bypassed");
    @(negedge clk);
    range_base = 32'h0000_1000;
    cpu_rd(32'h1024, pat(32'h1024), 0, "R10 back in range hits");

    // R8 invalidate discards held data with no write-back
    cpu_wr(32'h1024, 32'hD5D5_0005, 0, "R8 held write before invalidate");
    @(negedge clk);
    w0 = wr_cnt;
    #2 inv_all = 1'b1;
    @(negedge clk);
    #2 inv_all = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_cnt == w0, "R8 invalidate writes nothing", 32'(wr_cnt - w0), 32'd0);
    wr_hold = 1'b0;
    cpu_rd(32'h1024, pat(32'h1024), 4, "R8 line cleared");
    cpu_rd(32'h1100, 32'hD2D2_0002, 4, "R8 other line cleared");

    // R9 invalidate during a fill
    fork
      cpu_rd(32'h1140, pat(32'h1140), 4, "R9 fill completes");
      begin
        repeat (3) @(negedge clk);
        #2 inv_all = 1'b1;
        @(negedge clk);
        #2 inv_all = 1'b0;
      end
    join
    cpu_rd(32'h1140, pat(32'h1140), 4, "R9 filled line cleared after");

    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule